// File: doc/BRIEF.md
# Sleep Power-Reduction Sequencer

This block decides when a flash array may drop into its low-power state around system sleep, and when it must come back. It watches a sleep-entry pulse, a sleep-exit pulse and a memory access request. It drives a power-down level to the array. It also drives a stall back to the requester while the array is unavailable. A 2-bit mode input picks the wake-up policy. In mode 0 the array wakes only when something accesses it. In mode 1 it wakes as soon as sleep ends. Modes 2 and 3 disable automatic power-down.

The sequencer has three states: on, off and waking. The waking phase lasts a fixed, parameterised number of cycles before the array is usable again. The mode is sampled at the moment sleep is entered and governs the whole sleep episode. A sleep-entry request that arrives in the middle of a wake-up is remembered. It takes effect once the array is back on.

Top module: `sleep_pwr_seq`

## Requirements
- R1: After reset, and whenever reset is asserted, `pwr_down` is 0 and `acc_stall` is 0 with no access pending.
- R2: With `mode` 0 or 1 and the array on, a one-cycle `sleep_enter` makes `pwr_down` 1 from the next cycle on.
- R3: While powered down, an `acc_req` starts the wake-up in any sleep mode; `pwr_down` falls on the cycle after the request is first seen.
- R4: With `mode` 1 sampled at sleep entry, a `sleep_exit` pulse while powered down starts the wake-up; `pwr_down` falls on the next cycle.
- R5: With `mode` 2 or 3, `sleep_enter` is ignored and `pwr_down` stays 0.
- R6: The wake-up lasts exactly `WAKE_CYC` cycles (default 4). An access held from the cycle that triggers the wake-up is stalled for `WAKE_CYC`+1 cycles. An access held from the first waking cycle is stalled for `WAKE_CYC` cycles.
- R7: `acc_stall` is 1 only while `acc_req` is 1 and the array is off or waking; accesses to an awake array are never stalled.
- R8: A `sleep_enter` seen during wake-up is held. The wake-up completes, the array stays on for one cycle, and then `pwr_down` rises.
- R9: The wake policy is taken from `mode` at sleep entry; later changes of `mode` during the same sleep do not alter which event wakes the array.
- R10: With `mode` 0 sampled at entry, `sleep_exit` does not wake the array. A repeated `sleep_enter` while powered down does not restart anything. A `sleep_exit` while on has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Wake policy: 0 wake on access, 1 wake on sleep exit, 2/3 no power-down |
| sleep_enter | input | 1 | One-cycle pulse: system is entering sleep |
| sleep_exit | input | 1 | One-cycle pulse: system is leaving sleep |
| acc_req | input | 1 | Memory access request, held until not stalled |
| pwr_down | output | 1 | Array in low-power state |
| acc_stall | output | 1 | Hold off the current access |

## Verification
Every mode value is crossed with both wake triggers: an access, and a sleep-exit pulse followed by an access. Comparing the measured stall length, WAKE_CYC+1, WAKE_CYC or 0, separates a trigger that woke the array from one that was ignored, and separates a disabled mode from a working one. Targeted runs change `mode` mid-sleep to tell a latched policy from a live one. They also pulse `sleep_enter` during waking to tell a deferred request from one that is dropped or taken early. Repeated entry and exit pulses in the wrong state confirm that those pulses change nothing.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int MODE_W = 2;

    typedef enum logic [1:0] {
        ST_ON   = 2'd0,
        ST_OFF  = 2'd1,
        ST_WAKE = 2'd2
    } pwr_st_e;

    typedef struct packed {
        pwr_st_e st;
        logic    exit_wake;
        logic    pend;
    } ctrl_reg_t;
endpackage

// File: rtl/sps_mode_dec.sv
module sps_mode_dec
    import sps_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              pd_en,
    output logic              exit_wake
);
    // 0: wake on access, 1: wake on sleep exit, 2 (reserved) and 3: no power-down
    always_comb begin
        pd_en     = (mode == MODE_W'(0)) || (mode == MODE_W'(1));
        exit_wake = (mode == MODE_W'(1));
    end
endmodule

// File: rtl/sps_wake_timer.sv
module sps_wake_timer #(
    parameter int WAKE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = (WAKE_CYC > 1) ? $clog2(WAKE_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        done  = tmr_q.run && (tmr_q.cnt == LAST);
        if (start) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (done) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    a_r6_runs_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !done && !start) |=> tmr_q.run);
    a_r6_stops_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !tmr_q.run);
endmodule

// File: rtl/sps_ctrl.sv
module sps_ctrl
    import sps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_enter,
    input  logic sleep_exit,
    input  logic acc_req,
    input  logic pd_en,
    input  logic exit_wake_live,
    input  logic tmr_done,
    output logic tmr_start,
    output logic pwr_down,
    output logic acc_stall
);
    ctrl_reg_t ctl_d, ctl_q;
    logic      wake_trig;

    always_comb begin
        ctl_d     = ctl_q;
        tmr_start = 1'b0;
        wake_trig = acc_req || (ctl_q.exit_wake && sleep_exit);
        unique case (ctl_q.st)
            ST_ON: begin
                if (sleep_enter || ctl_q.pend) begin
                    ctl_d.pend = 1'b0;
                    if (pd_en) begin
                        ctl_d.st        = ST_OFF;
                        ctl_d.exit_wake = exit_wake_live;
                    end
                end
            end
            ST_OFF: begin
                if (wake_trig) begin
                    ctl_d.st  = ST_WAKE;
                    tmr_start = 1'b1;
                end
            end
            ST_WAKE: begin
                if (sleep_enter) ctl_d.pend = 1'b1;
                if (tmr_done)    ctl_d.st   = ST_ON;
            end
            default: ctl_d.st = ST_ON;
        endcase
        pwr_down  = (ctl_q.st == ST_OFF);
        acc_stall = acc_req && (ctl_q.st != ST_ON);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_ON, exit_wake: 1'b0, pend: 1'b0};
        else        ctl_q <= ctl_d;
    end

    a_r2_entry_powers_down: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ON && sleep_enter && pd_en) |=> pwr_down);
    a_r5_disabled_stays_on: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ON && !pd_en) |=> !pwr_down);
    a_r3_access_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && acc_req) |=> (!pwr_down && acc_stall == acc_req));
    a_r10_down_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && !acc_req && !sleep_exit) |=> pwr_down);
    a_r8_no_entry_while_waking: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAKE) |=> !pwr_down);
endmodule

// File: rtl/sleep_pwr_seq.sv
module sleep_pwr_seq
    import sps_pkg::*;
#(
    parameter int WAKE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              sleep_enter,
    input  logic              sleep_exit,
    input  logic              acc_req,
    output logic              pwr_down,
    output logic              acc_stall
);
    logic pd_en, exit_wake_live, tmr_start, tmr_done;

    sps_mode_dec dec_i (
        .mode      (mode),
        .pd_en     (pd_en),
        .exit_wake (exit_wake_live)
    );

    sps_wake_timer #(.WAKE_CYC(WAKE_CYC)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    sps_ctrl ctrl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .sleep_enter    (sleep_enter),
        .sleep_exit     (sleep_exit),
        .acc_req        (acc_req),
        .pd_en          (pd_en),
        .exit_wake_live (exit_wake_live),
        .tmr_done       (tmr_done),
        .tmr_start      (tmr_start),
        .pwr_down       (pwr_down),
        .acc_stall      (acc_stall)
    );
endmodule

// File: tb/sleep_pwr_seq_tb.sv
module sleep_pwr_seq_tb_top;
    localparam int CLK_P = 10;
    localparam int WAKE  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       sleep_enter = 1'b0, sleep_exit = 1'b0, acc_req = 1'b0;
    logic       pwr_down, acc_stall;
    int         n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_P/2) clk = ~clk;

    sleep_pwr_seq #(.WAKE_CYC(WAKE)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sleep_enter(sleep_enter),
        .sleep_exit(sleep_exit), .acc_req(acc_req),
        .pwr_down(pwr_down), .acc_stall(acc_stall)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_enter = 0; sleep_exit = 0; acc_req = 0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", pwr_down, 0);
        chk("R1", acc_stall, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic go_sleep();
        sleep_enter = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0;
    endtask

    task automatic pulse_exit();
        sleep_exit = 1'b1;
        @(negedge clk);
        sleep_exit = 1'b0;
    endtask

    // hold an access until granted; return the number of stalled cycles
    task automatic measure_stall(output int n);
        acc_req = 1'b1;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            #1;
            if (acc_stall) n++;
            else break;
            @(negedge clk);
        end
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_chk++; n_bad++;
            $display("FAIL R6 watchdog: actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, k;
        // sweep: every mode x {access trigger, exit trigger}
        for (int m = 0; m < 4; m++) begin
            for (int trig = 0; trig < 2; trig++) begin
                do_reset();
                mode = 2'(m);
                @(negedge clk);
                go_sleep();
                #1;
                chk((m < 2) ? "R2" : "R5", pwr_down, (m < 2) ? 1 : 0);
                repeat (3) @(negedge clk);
                #1;
                chk((m < 2) ? "R10" : "R5", pwr_down, (m < 2) ? 1 : 0);
                if (trig == 1) begin
                    pulse_exit();
                    #1;
                    chk((m == 1) ? "R4" : "R10", pwr_down, (m == 0) ? 1 : 0);
                    measure_stall(n);
                    chk("R6", n, (m == 1) ? WAKE : ((m == 0) ? WAKE + 1 : 0));
                end else begin
                    measure_stall(n);
                    chk("R3", n, (m < 2) ? WAKE + 1 : 0);
                end
                #1;
                chk("R7", pwr_down, 0);
                measure_stall(n);
                chk("R7", n, 0);
            end
        end

        // R8: sleep_enter during wake-up is deferred
        do_reset();
        mode = 2'd0;
        go_sleep();
        acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        sleep_enter = 1'b1;
        @(negedge clk);
        sleep_enter = 1'b0;
        k = 2;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (pwr_down) break;
            k++;
            @(negedge clk);
        end
        chk("R8", k, WAKE + 2);

        // R9: mode changed after entry does not change the wake policy
        do_reset();
        mode = 2'd1;
        go_sleep();
        mode = 2'd0;
        pulse_exit();
        #1;
        chk("R9", pwr_down, 0);
        do_reset();
        mode = 2'd0;
        go_sleep();
        mode = 2'd1;
        pulse_exit();
        #1;
        chk("R9", pwr_down, 1);
        mode = 2'd3;
        measure_stall(n);
        chk("R9", n, WAKE + 1);

        // R10: repeated entry while down, exit while on
        do_reset();
        mode = 2'd0;
        go_sleep();
        @(negedge clk);
        go_sleep();
        #1;
        chk("R10", pwr_down, 1);
        measure_stall(n);
        chk("R10", n, WAKE + 1);
        pulse_exit();
        #1;
        chk("R10", pwr_down, 0);
        measure_stall(n);
        chk("R10", n, 0);

        // R1: reset in the middle of sleep
        go_sleep();
        #1;
        chk("R2", pwr_down, 1);
        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule